// File: doc/BRIEF.md
# Feedback-Gated Dead-Time Sequencer

This block sits between the switching control of a synchronous buck stage and its two gate drivers. It receives separate requests for the high-side and low-side switches and produces the two enables that actually reach the drivers. It never hands over from one switch to the other on a timer alone. First it removes the enable of the switch that is on, after a parameterised turn-off propagation delay. Then it waits until the feedback flag of that switch reports that its gate has fallen below threshold. Only after that flag has held for a fixed, parameterised non-overlap interval does it assert the other enable.

The two gate feedback flags are synchronous digital inputs. The analog sensing that produces them is outside this block. A kill input, driven by a disable condition or by a decoded all-off command, clears both enables in the same cycle without waiting for any delay. After a kill, every turn-on sequence starts again from the idle state. All delays are counted in clock cycles. With a 100 MHz clock the defaults are 2 cycles for high-side turn-off, 4 for low-side turn-off, 3 for the low-to-high non-overlap interval and 2 for the high-to-low interval.

Top module: `gate_nov_top`

## Requirements
- R1: `hs_en` and `ls_en` are never both 1 in the same cycle.
- R2: `hs_en` rises only while the high-side request wins. Before it rises, `ls_en` must already be 0 and `ls_fb_low` must have been sampled 1 on `HL_DT` consecutive clock edges, the last of which is the edge on which `hs_en` rises.
- R3: `ls_en` rises only while `ls_req`=1 and `hs_req`=0. Before it rises, `hs_en` must already be 0 and `hs_fb_low` must have been sampled 1 on `LH_DT` consecutive clock edges, the last of which is the edge on which `ls_en` rises.
- R4: once the high-side request stops winning, `hs_en` stays 1 for `HS_OFF_DLY`-1 further edges and falls on the `HS_OFF_DLY`-th edge. It stays 1 on every edge at which `hs_req`=1 and `kill`=0.
- R5: once the low-side request stops winning, `ls_en` falls on the `LS_OFF_DLY`-th edge. It stays 1 on every edge at which `ls_req`=1, `hs_req`=0 and `kill`=0.
- R6: `kill`=1 forces both enables to 0 combinationally, in the same cycle. Both enables stay 0 in the cycle after the kill. Any later turn-on runs its full non-overlap interval afresh.
- R7: while the opposite feedback flag stays 0, the pending enable stays 0 indefinitely. A single 0 on that flag during the non-overlap interval restarts the interval.
- R8: a change of the winning request restarts the shared counter. This applies during a non-overlap wait, which is abandoned, and during a turn-off delay, where the gate stays on.
- R9: when `hs_req` and `ls_req` are both 1, the high-side request wins.
- R10: after a synchronous reset (`rst_n`=0 on a clock edge), both enables are 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hs_req | input | 1 | High-side switch request |
| ls_req | input | 1 | Low-side switch request |
| hs_fb_low | input | 1 | 1 when the high-side gate is below threshold |
| ls_fb_low | input | 1 | 1 when the low-side gate is below threshold |
| kill | input | 1 | Immediate all-off override |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
A turn-on enable appears on the clock edge that counts the last cycle of the non-overlap interval. That interval is measured from the first edge on which the opposite feedback flag is sampled low. A turn-off appears on the edge that ends the propagation delay, and a kill takes effect within the cycle it is applied. The bench drives inputs on the falling clock edge and compares the enables on the next falling edge. Every vector therefore covers exactly one rising edge, and the delay counts in the expected column are counted edge by edge. The single combinational path, from kill to the enables, is checked separately one time unit after kill is driven, with no clock edge in between.

// File: rtl/gate_nov_pkg.sv
// Shared types for the dead-time sequencer.
// Assumes: one-hot request decoding is done by nov_target_sel.
package gate_nov_pkg;

    // Sequencer phases: idle, waiting for a side to turn on, or a side on.
    typedef enum logic [2:0] {
        NV_IDLE    = 3'd0,
        NV_WAIT_HS = 3'd1,
        NV_HS_ON   = 3'd2,
        NV_WAIT_LS = 3'd3,
        NV_LS_ON   = 3'd4
    } nov_state_t;

    // Side that currently wins the request arbitration.
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_HS   = 2'd1,
        TGT_LS   = 2'd2
    } nov_tgt_t;

endpackage

// File: rtl/nov_target_sel.sv
// Request arbiter: turns the two raw requests into a single target side.
// Assumes: high-side request has priority when both are raised.
module nov_target_sel
    import gate_nov_pkg::*;
(
    input  logic     hs_req,
    input  logic     ls_req,
    output nov_tgt_t tgt
);

    // Priority decode, high side first.
    always_comb begin
        if (hs_req)      tgt = TGT_HS;
        else if (ls_req) tgt = TGT_LS;
        else             tgt = TGT_NONE;
    end

endmodule

// File: rtl/nov_delay_cnt.sv
// Shared delay counter: cleared or advanced by the sequencer each cycle.
// Assumes: the sequencer never advances past its own limit.
module nov_delay_cnt #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);

    // Synchronous clear has priority over advance.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (inc)      count <= count + 1'b1;
    end

endmodule

// File: rtl/nov_seq.sv
// Phase sequencer: decides turn-off, dead-time wait and turn-on.
// Assumes: delays are at least one cycle; feedback flags are synchronous.
module nov_seq
    import gate_nov_pkg::*;
#(
    parameter int HS_OFF_DLY = 2,
    parameter int LS_OFF_DLY = 4,
    parameter int HL_DT      = 3,
    parameter int LH_DT      = 2,
    parameter int CW         = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  nov_tgt_t      tgt,
    input  logic          hs_fb_low,
    input  logic          ls_fb_low,
    input  logic          kill,
    input  logic [CW-1:0] cnt,
    output logic          cnt_clr,
    output logic          cnt_inc,
    output nov_state_t    state
);

    localparam logic [CW-1:0] HS_OFF_LAST = CW'(HS_OFF_DLY - 1);
    localparam logic [CW-1:0] LS_OFF_LAST = CW'(LS_OFF_DLY - 1);
    localparam logic [CW-1:0] HL_LAST     = CW'(HL_DT - 1);
    localparam logic [CW-1:0] LH_LAST     = CW'(LH_DT - 1);

    nov_state_t    nxt;
    logic [CW-1:0] last;
    logic          done;

    // Pick the counter limit that belongs to the current phase.
    always_comb begin
        case (state)
            NV_WAIT_HS: last = HL_LAST;
            NV_WAIT_LS: last = LH_LAST;
            NV_HS_ON:   last = HS_OFF_LAST;
            NV_LS_ON:   last = LS_OFF_LAST;
            default:    last = '0;
        endcase
    end

    assign done = (cnt == last);

    // Next-phase and counter control decode.
    always_comb begin
        nxt     = state;
        cnt_clr = 1'b1;
        cnt_inc = 1'b0;
        if (kill) begin
            nxt = NV_IDLE;
        end else begin
            case (state)
                NV_IDLE: begin
                    if (tgt == TGT_HS)      nxt = NV_WAIT_HS;
                    else if (tgt == TGT_LS) nxt = NV_WAIT_LS;
                end
                NV_WAIT_HS: begin
                    if (tgt != TGT_HS) begin
                        nxt = (tgt == TGT_LS) ? NV_WAIT_LS : NV_IDLE;
                    end else if (ls_fb_low) begin
                        if (done) nxt = NV_HS_ON;
                        else begin
                            cnt_clr = 1'b0;
                            cnt_inc = 1'b1;
                        end
                    end
                end
                NV_WAIT_LS: begin
                    if (tgt != TGT_LS) begin
                        nxt = (tgt == TGT_HS) ? NV_WAIT_HS : NV_IDLE;
                    end else if (hs_fb_low) begin
                        if (done) nxt = NV_LS_ON;
                        else begin
                            cnt_clr = 1'b0;
                            cnt_inc = 1'b1;
                        end
                    end
                end
                NV_HS_ON: begin
                    if (tgt != TGT_HS) begin
                        if (done) nxt = (tgt == TGT_LS) ? NV_WAIT_LS : NV_IDLE;
                        else begin
                            cnt_clr = 1'b0;
                            cnt_inc = 1'b1;
                        end
                    end
                end
                NV_LS_ON: begin
                    if (tgt != TGT_LS) begin
                        if (done) nxt = (tgt == TGT_HS) ? NV_WAIT_HS : NV_IDLE;
                        else begin
                            cnt_clr = 1'b0;
                            cnt_inc = 1'b1;
                        end
                    end
                end
                default: nxt = NV_IDLE;
            endcase
        end
    end

    // Phase register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= NV_IDLE;
        else        state <= nxt;
    end

endmodule

// File: rtl/gate_nov_top.sv
// Dead-time sequencer top: arbitration, sequencer, counter, enable decode.
// Assumes: kill is synchronous to clk; all delays are >= 1 cycle.
module gate_nov_top
    import gate_nov_pkg::*;
#(
    parameter int HS_OFF_DLY = 2,
    parameter int LS_OFF_DLY = 4,
    parameter int HL_DT      = 3,
    parameter int LH_DT      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_req,
    input  logic ls_req,
    input  logic hs_fb_low,
    input  logic ls_fb_low,
    input  logic kill,
    output logic hs_en,
    output logic ls_en
);

    localparam int MAX_A = (HS_OFF_DLY > LS_OFF_DLY) ? HS_OFF_DLY : LS_OFF_DLY;
    localparam int MAX_B = (HL_DT > LH_DT) ? HL_DT : LH_DT;
    localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = (MAX_D < 2) ? 1 : $clog2(MAX_D);

    nov_tgt_t      tgt;
    nov_state_t    state;
    logic [CW-1:0] cnt;
    logic          cnt_clr;
    logic          cnt_inc;

    nov_target_sel u_sel (
        .hs_req (hs_req),
        .ls_req (ls_req),
        .tgt    (tgt)
    );

    nov_seq #(
        .HS_OFF_DLY (HS_OFF_DLY),
        .LS_OFF_DLY (LS_OFF_DLY),
        .HL_DT      (HL_DT),
        .LH_DT      (LH_DT),
        .CW         (CW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tgt       (tgt),
        .hs_fb_low (hs_fb_low),
        .ls_fb_low (ls_fb_low),
        .kill      (kill),
        .cnt       (cnt),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .state     (state)
    );

    nov_delay_cnt #(
        .CW (CW)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (cnt)
    );

    // Enable decode; kill masks both enables within the cycle.
    always_comb begin
        hs_en = (state == NV_HS_ON) && !kill;
        ls_en = (state == NV_LS_ON) && !kill;
    end

    // R1
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    // R2
    hs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> ($past(ls_fb_low) && $past(hs_req) && !$past(ls_en)));

    // R3
    ls_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> ($past(hs_fb_low) && $past(ls_req) && !$past(hs_req) && !$past(hs_en)));

    // R4
    hs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && hs_req && !kill) |=> (hs_en || kill));

    // R5
    ls_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_en && ls_req && !hs_req && !kill) |=> (ls_en || kill));

    // R6
    kill_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (!hs_en && !ls_en));

endmodule

// File: tb/sim_gate_nov_top.sv
// Bench for gate_nov_top: a vector table walked one clock edge per row,
// then directed checks for same-cycle kill and mid-run reset.
module sim_gate_nov_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_req = 1'b0, ls_req = 1'b0;
    logic hs_fb_low = 1'b1, ls_fb_low = 1'b1;
    logic kill = 1'b0;
    logic hs_en, ls_en;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    gate_nov_top #(
        .HS_OFF_DLY (2),
        .LS_OFF_DLY (4),
        .HL_DT      (3),
        .LH_DT      (2)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs_req    (hs_req),
        .ls_req    (ls_req),
        .hs_fb_low (hs_fb_low),
        .ls_fb_low (ls_fb_low),
        .kill      (kill),
        .hs_en     (hs_en),
        .ls_en     (ls_en)
    );

    // Row: {hs_req, ls_req, hs_fb_low, ls_fb_low, kill, exp_hs, exp_ls}
    localparam int NV = 49;
    localparam logic [6:0] VEC [NV] = '{
        7'b00110_00, // 1  idle stays idle
        7'b01100_00, // 2  R3 wait low side
        7'b01100_00, // 3  R3 dead time 1
        7'b01100_01, // 4  R3 low side on
        7'b01100_01, // 5  R5 held
        7'b10100_01, // 6  R5 turn-off 1
        7'b10100_01, // 7
        7'b10100_01, // 8
        7'b10100_00, // 9  R5 off on 4th edge
        7'b10100_00, // 10 R7 feedback not low
        7'b10100_00, // 11 R7
        7'b10110_00, // 12 R2 dead time 1
        7'b10110_00, // 13 R2 dead time 2
        7'b10110_10, // 14 R2 high side on
        7'b01010_10, // 15 R4 turn-off 1
        7'b01010_00, // 16 R4 off on 2nd edge
        7'b01010_00, // 17 R7 hs feedback not low
        7'b01110_00, // 18 R3
        7'b01110_01, // 19 R3 low side on
        7'b01101_00, // 20 R6 kill
        7'b01100_00, // 21 R6 restart
        7'b01100_00, // 22 R6
        7'b01100_01, // 23 R6 full interval again
        7'b11100_01, // 24 R9 both requests
        7'b01100_01, // 25 R8 request returns, gate stays
        7'b11100_01, // 26 R8 turn-off restarted
        7'b11100_01, // 27
        7'b11100_01, // 28
        7'b11100_00, // 29 R9 high side wins
        7'b10110_00, // 30 R2
        7'b10110_00, // 31
        7'b00110_00, // 32 R8 request drop abandons wait
        7'b10110_00, // 33 R8
        7'b10110_00, // 34
        7'b10110_00, // 35
        7'b10110_10, // 36 R8 full interval
        7'b00010_10, // 37 R4
        7'b00010_00, // 38 R4 off
        7'b10110_00, // 39
        7'b10110_00, // 40
        7'b10110_00, // 41
        7'b10110_10, // 42
        7'b10011_00, // 43 R6 kill high side
        7'b10110_00, // 44 R6
        7'b10110_00, // 45 R7
        7'b10100_00, // 46 R7 feedback lost, restart
        7'b10110_00, // 47 R7
        7'b10110_00, // 48 R7
        7'b10110_10  // 49 R7 on after full interval
    };

    // Requirement tag attached to each table row.
    function automatic string row_tag(input int r);
        if (r <= 4)       return "R3";
        else if (r <= 9)  return "R5";
        else if (r <= 14) return "R2";
        else if (r <= 16) return "R4";
        else if (r <= 19) return "R7";
        else if (r <= 23) return "R6";
        else if (r == 24) return "R9";
        else if (r <= 28) return "R8";
        else if (r == 29) return "R9";
        else if (r <= 36) return "R8";
        else if (r <= 42) return "R4";
        else if (r <= 44) return "R6";
        else              return "R7";
    endfunction

    task automatic check(input string tag, input logic eh, input logic el);
        checks++;
        if (hs_en !== eh || ls_en !== el) begin
            errors++;
            $display("FAIL %s: hs_en/ls_en=%b%b expected %b%b", tag, hs_en, ls_en, eh, el);
        end
        checks++;
        if (hs_en === 1'b1 && ls_en === 1'b1) begin
            errors++;
            $display("FAIL R1: both enables high, actual 11 expected not 11");
        end
    endtask

    initial begin
        #2_000_000;
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        @(negedge clk);
        @(negedge clk);
        check("R10", 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            {hs_req, ls_req, hs_fb_low, ls_fb_low, kill} = VEC[i][6:2];
            @(negedge clk);
            check(row_tag(i + 1), VEC[i][1], VEC[i][0]);
        end

        // R6 same-cycle kill: high side is on after row 49
        kill = 1'b1;
        #1;
        check("R6", 1'b0, 1'b0);
        @(negedge clk);
        kill = 1'b0;
        check("R6", 1'b0, 1'b0);

        // bring high side back on, then R10 reset mid-run
        repeat (4) @(negedge clk);
        check("R2", 1'b1, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", 1'b0, 1'b0);
        rst_n = 1'b1;
        hs_req = 1'b0;
        @(negedge clk);
        check("R10", 1'b0, 1'b0);

        done_flag = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule